// File: doc/BRIEF.md
# Power-Up Sequencing Controller

This block orders the start-up of a four-channel bias output device after any reset event. Four reset sources lead into it: an asynchronous power-on reset, a low level on an external reset pin, a software reset pulse and a serial-bus general-call reset pulse. From the reset state the controller runs its phases in a fixed order. It first requests a non-volatile configuration load and keeps the host interface shut until that load completes. It then releases the outputs from supply clamp while the output switches stay forced off. In autonomous mode it may wait for a wide-range supply to become valid, runs two temperature conversions, passes only the second result on to the lookup table and pulses a load of the four DAC data words.

The last phase is a current-limited settle interval whose length comes from a 2-bit field. After that interval the controller raises the power-amplifier enable, releases the output switches to the user and applies the configured current-limit mode. It then holds in a done state until the next reset. The configuration memory, the temperature sensor and the table arithmetic lie outside the block and are reached through request/done handshakes. The current phase is visible on a status output.

Top module: `pwrseq_ctrl`

## Requirements
- R1: Power-on reset low forces the reset state at once. A low `ext_rst_n`, or a high `sw_rst` or `gc_rst` sampled at a clock edge, puts the controller in the reset state after that edge. This holds in every phase.
- R2: In the reset state `clamp_vss`=1, `pa_on`=0, `sw_force_off`=1, `comm_en`=0 and `dac_clear`=4'b1111. The reset state lasts one cycle when no reset source stays active, and the controller then enters the configuration-load phase.
- R3: In the configuration-load phase `cfg_load_req`=1, `comm_en`=0 and `clamp_vss`=1. The phase ends at the edge where `cfg_load_done` is sampled high.
- R4: After the configuration load, `clamp_vss`=0 and `comm_en`=1 in every phase. `sw_force_off` stays 1 until the done state.
- R5: With `cfg_auto`=1 and `cfg_wide_vss`=1 the controller waits in the supply-wait phase until `vss_ok` is high. With `cfg_wide_vss`=0 it goes straight from the configuration load to the first conversion.
- R6: In autonomous mode two conversions run in turn, with `temp_req`=1 during both. `lut_capture` follows `temp_done` only during the second conversion. One cycle of `dac_load`=1 follows the second conversion.
- R7: The settle phase lasts exactly `(CLK_HZ/1000) << cfg_tmr_sel` cycles, which is 1, 2, 4 or 8 ms for `cfg_tmr_sel` 0 to 3. The field is sampled on entry to the phase. `startup_ilim`=1 exactly during the settle phase.
- R8: In the done state `pa_on`=1, `sw_force_off`=0, `startup_ilim`=0 and `ilim_hi` follows `cfg_ilim_hi`. Outside the done state `ilim_hi`=0 and `pa_on`=0.
- R9: With `cfg_auto`=0 the controller goes from the configuration load straight to the settle phase. No conversion request and no `dac_load` occur.
- R10: The done state holds, whatever the other inputs do, until a reset source is active.
- R11: `state_o` encodes the phases as 0 reset, 1 configuration load, 2 supply wait, 3 first conversion, 4 second conversion, 5 DAC load, 6 settle, 7 done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin level, active low |
| sw_rst | input | 1 | Software reset command pulse |
| gc_rst | input | 1 | Serial-bus general-call reset pulse |
| cfg_load_req | output | 1 | Request for the configuration memory load |
| cfg_load_done | input | 1 | Configuration load complete pulse |
| cfg_auto | input | 1 | Autonomous operation enable |
| cfg_wide_vss | input | 1 | Wide-range supply option, enables the supply wait |
| cfg_tmr_sel | input | 2 | Settle duration select (1, 2, 4, 8 ms) |
| cfg_ilim_hi | input | 1 | Current-limit mode applied after settle |
| vss_ok | input | 1 | Supply within its valid range |
| temp_req | output | 1 | Temperature conversion request |
| temp_done | input | 1 | Conversion complete pulse |
| lut_capture | output | 1 | Pass the current conversion result to the table |
| dac_load | output | 1 | Load table-generated values into the four DAC words |
| dac_clear | output | 4 | Per-DAC data clear to zero |
| clamp_vss | output | 1 | All DACs in supply-clamp mode |
| sw_force_off | output | 1 | Output switches forced off |
| comm_en | output | 1 | Host communication enabled |
| startup_ilim | output | 1 | Start-up current mode (limited source/sink current) |
| ilim_hi | output | 1 | Configured current-limit mode after settle |
| pa_on | output | 1 | Power-amplifier enable |
| state_o | output | 3 | Current phase code |

## Verification
The bench builds the controller with `CLK_HZ` = 8000, so one millisecond is eight cycles and every settle length from 8 to 64 cycles is measured within a short run. The configuration-load and conversion responders use latencies of a few cycles. This brings resets in the middle of each phase, held supply waits and long holds in the done state all within reach. A behavioural model in the bench follows the phase order and the settle countdown with plain integers and is compared with every output on every clock.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        PH_RESET   = 3'd0,
        PH_CFGLOAD = 3'd1,
        PH_VSSWAIT = 3'd2,
        PH_TEMP1   = 3'd3,
        PH_TEMP2   = 3'd4,
        PH_DACLOAD = 3'd5,
        PH_SETTLE  = 3'd6,
        PH_DONE    = 3'd7
    } phase_t;

    typedef struct packed {
        phase_t ph;
        logic   auto_en;
    } seq_t;

    typedef struct packed {
        logic clamp_vss;
        logic sw_force_off;
        logic comm_en;
        logic cfg_load_req;
        logic temp_req;
        logic lut_capture;
        logic dac_load;
        logic startup_ilim;
        logic ilim_hi;
        logic pa_on;
        logic clear_all;
    } outs_t;

endpackage

// File: rtl/pwrseq_rst_merge.sv
module pwrseq_rst_merge #(
    parameter int N_SRC = 3
) (
    input  logic [N_SRC-1:0] src_active,
    output logic             any_active
);
    logic [N_SRC:0] chain;

    assign chain[0] = 1'b0;

    for (genvar i = 0; i < N_SRC; i++) begin : g_or
        assign chain[i+1] = chain[i] | src_active[i];
    end

    assign any_active = chain[N_SRC];

endmodule

// File: rtl/pwrseq_settle_timer.sv
module pwrseq_settle_timer #(
    parameter int CLK_HZ = 50_000_000,
    parameter int SEL_W  = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             start,
    input  logic [SEL_W-1:0] sel,
    output logic             expired
);
    localparam int TICKS_PER_MS = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
    localparam int N_SEL        = 1 << SEL_W;
    localparam int MAX_TICKS    = TICKS_PER_MS << (N_SEL - 1);
    localparam int CNT_W        = $clog2(MAX_TICKS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] left;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    logic [CNT_W-1:0] load_tbl [N_SEL];

    for (genvar k = 0; k < N_SEL; k++) begin : g_load
        assign load_tbl[k] = CNT_W'((TICKS_PER_MS << k) - 1);
    end

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.left = load_tbl[sel];
        end else if (tmr_q.left != '0) begin
            tmr_d.left = tmr_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expired = (tmr_q.left == '0);

endmodule

// File: rtl/pwrseq_out_decode.sv
module pwrseq_out_decode
    import pwrseq_pkg::*;
(
    input  phase_t ph,
    input  logic   temp_done,
    input  logic   ilim_cfg,
    output outs_t  o
);
    always_comb begin
        o              = '0;
        o.sw_force_off = 1'b1;
        o.comm_en      = 1'b1;
        unique case (ph)
            PH_RESET: begin
                o.clamp_vss = 1'b1;
                o.comm_en   = 1'b0;
                o.clear_all = 1'b1;
            end
            PH_CFGLOAD: begin
                o.clamp_vss    = 1'b1;
                o.comm_en      = 1'b0;
                o.cfg_load_req = 1'b1;
            end
            PH_VSSWAIT: begin
            end
            PH_TEMP1: begin
                o.temp_req = 1'b1;
            end
            PH_TEMP2: begin
                o.temp_req    = 1'b1;
                o.lut_capture = temp_done;
            end
            PH_DACLOAD: begin
                o.dac_load = 1'b1;
            end
            PH_SETTLE: begin
                o.startup_ilim = 1'b1;
            end
            PH_DONE: begin
                o.sw_force_off = 1'b0;
                o.pa_on        = 1'b1;
                o.ilim_hi      = ilim_cfg;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int N_DAC  = 4,
    parameter int SEL_W  = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             ext_rst_n,
    input  logic             sw_rst,
    input  logic             gc_rst,
    output logic             cfg_load_req,
    input  logic             cfg_load_done,
    input  logic             cfg_auto,
    input  logic             cfg_wide_vss,
    input  logic [SEL_W-1:0] cfg_tmr_sel,
    input  logic             cfg_ilim_hi,
    input  logic             vss_ok,
    output logic             temp_req,
    input  logic             temp_done,
    output logic             lut_capture,
    output logic             dac_load,
    output logic [N_DAC-1:0] dac_clear,
    output logic             clamp_vss,
    output logic             sw_force_off,
    output logic             comm_en,
    output logic             startup_ilim,
    output logic             ilim_hi,
    output logic             pa_on,
    output logic [2:0]       state_o
);
    localparam int N_SOFT = 3;

    logic              soft_rst;
    logic              tmr_start;
    logic              tmr_expired;
    logic [N_SOFT-1:0] soft_src;
    seq_t              seq_d, seq_q;
    outs_t             dec;

    assign soft_src = {gc_rst, sw_rst, ~ext_rst_n};

    pwrseq_rst_merge #(
        .N_SRC(N_SOFT)
    ) u_rst_merge (
        .src_active(soft_src),
        .any_active(soft_rst)
    );

    always_comb begin
        seq_d = seq_q;
        if (soft_rst) begin
            seq_d.ph      = PH_RESET;
            seq_d.auto_en = 1'b0;
        end else begin
            unique case (seq_q.ph)
                PH_RESET: begin
                    seq_d.ph = PH_CFGLOAD;
                end
                PH_CFGLOAD: begin
                    if (cfg_load_done) begin
                        seq_d.auto_en = cfg_auto;
                        if (!cfg_auto) begin
                            seq_d.ph = PH_SETTLE;
                        end else if (cfg_wide_vss) begin
                            seq_d.ph = PH_VSSWAIT;
                        end else begin
                            seq_d.ph = PH_TEMP1;
                        end
                    end
                end
                PH_VSSWAIT: begin
                    if (vss_ok) begin
                        seq_d.ph = PH_TEMP1;
                    end
                end
                PH_TEMP1: begin
                    if (temp_done) begin
                        seq_d.ph = PH_TEMP2;
                    end
                end
                PH_TEMP2: begin
                    if (temp_done) begin
                        seq_d.ph = PH_DACLOAD;
                    end
                end
                PH_DACLOAD: begin
                    seq_d.ph = PH_SETTLE;
                end
                PH_SETTLE: begin
                    if (tmr_expired) begin
                        seq_d.ph = PH_DONE;
                    end
                end
                PH_DONE: begin
                    seq_d.ph = PH_DONE;
                end
                default: begin
                    seq_d.ph = PH_RESET;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            seq_q <= '{ph: PH_RESET, auto_en: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign tmr_start = (seq_d.ph == PH_SETTLE) && (seq_q.ph != PH_SETTLE);

    pwrseq_settle_timer #(
        .CLK_HZ(CLK_HZ),
        .SEL_W (SEL_W)
    ) u_timer (
        .clk    (clk),
        .por_n  (por_n),
        .start  (tmr_start),
        .sel    (cfg_tmr_sel),
        .expired(tmr_expired)
    );

    pwrseq_out_decode u_decode (
        .ph       (seq_q.ph),
        .temp_done(temp_done),
        .ilim_cfg (cfg_ilim_hi),
        .o        (dec)
    );

    assign cfg_load_req = dec.cfg_load_req;
    assign temp_req     = dec.temp_req;
    assign lut_capture  = dec.lut_capture;
    assign dac_load     = dec.dac_load;
    assign dac_clear    = {N_DAC{dec.clear_all}};
    assign clamp_vss    = dec.clamp_vss;
    assign sw_force_off = dec.sw_force_off;
    assign comm_en      = dec.comm_en;
    assign startup_ilim = dec.startup_ilim;
    assign ilim_hi      = dec.ilim_hi;
    assign pa_on        = dec.pa_on;
    assign state_o      = seq_q.ph;

endmodule

// File: rtl/pwrseq_ctrl_chk.sv
module pwrseq_ctrl_chk (
    input logic       clk,
    input logic       por_n,
    input logic       ext_rst_n,
    input logic       sw_rst,
    input logic       gc_rst,
    input logic       cfg_load_done,
    input logic       clamp_vss,
    input logic       sw_force_off,
    input logic       comm_en,
    input logic       dac_load,
    input logic       startup_ilim,
    input logic       ilim_hi,
    input logic       pa_on,
    input logic [2:0] state_o
);
    logic soft_any;
    assign soft_any = !ext_rst_n || sw_rst || gc_rst;

    assert_soft_reset_R1: assert property (@(posedge clk) disable iff (!por_n)
        soft_any |=> (state_o == 3'd0));

    assert_reset_outputs_R2: assert property (@(posedge clk) disable iff (!por_n)
        (state_o == 3'd0) |-> (clamp_vss && sw_force_off && !pa_on && !comm_en));

    assert_comm_after_load_R3: assert property (@(posedge clk) disable iff (!por_n)
        $rose(comm_en) |-> $past(cfg_load_done));

    assert_clamp_exclusive_R4: assert property (@(posedge clk) disable iff (!por_n)
        comm_en |-> !clamp_vss);

    assert_load_after_conv_R6: assert property (@(posedge clk) disable iff (!por_n)
        dac_load |-> ($past(state_o) == 3'd4));

    assert_pa_after_settle_R7: assert property (@(posedge clk) disable iff (!por_n)
        $rose(pa_on) |-> $past(startup_ilim));

    assert_limit_excl_R8: assert property (@(posedge clk) disable iff (!por_n)
        startup_ilim |-> (!ilim_hi && !pa_on && sw_force_off));

    assert_done_hold_R10: assert property (@(posedge clk) disable iff (!por_n)
        (state_o == 3'd7 && !soft_any) |=> (state_o == 3'd7));

endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .ext_rst_n    (ext_rst_n),
    .sw_rst       (sw_rst),
    .gc_rst       (gc_rst),
    .cfg_load_done(cfg_load_done),
    .clamp_vss    (clamp_vss),
    .sw_force_off (sw_force_off),
    .comm_en      (comm_en),
    .dac_load     (dac_load),
    .startup_ilim (startup_ilim),
    .ilim_hi      (ilim_hi),
    .pa_on        (pa_on),
    .state_o      (state_o)
);

// File: tb/pwrseq_ctrl_tb.sv
`timescale 1ns/1ps
module pwrseq_ctrl_tb;

    localparam int CLK_HZ   = 8000;
    localparam int TPM      = CLK_HZ / 1000;
    localparam int CFG_LAT  = 5;
    localparam int TEMP_LAT = 3;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       sw_rst = 1'b0;
    logic       gc_rst = 1'b0;
    logic       cfg_load_req;
    logic       cfg_load_done;
    logic       cfg_auto = 1'b0;
    logic       cfg_wide_vss = 1'b0;
    logic [1:0] cfg_tmr_sel = 2'd0;
    logic       cfg_ilim_hi = 1'b0;
    logic       vss_ok = 1'b0;
    logic       temp_req;
    logic       temp_done;
    logic       lut_capture;
    logic       dac_load;
    logic [3:0] dac_clear;
    logic       clamp_vss;
    logic       sw_force_off;
    logic       comm_en;
    logic       startup_ilim;
    logic       ilim_hi;
    logic       pa_on;
    logic [2:0] state_o;

    int n_checks = 0;
    int n_fails  = 0;
    int lut_pulses = 0;
    int temp_pulses = 0;
    int load_pulses = 0;

    always #10 clk = ~clk;

    pwrseq_ctrl #(.CLK_HZ(CLK_HZ)) u_dut (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .sw_rst(sw_rst), .gc_rst(gc_rst),
        .cfg_load_req(cfg_load_req), .cfg_load_done(cfg_load_done), .cfg_auto(cfg_auto),
        .cfg_wide_vss(cfg_wide_vss), .cfg_tmr_sel(cfg_tmr_sel), .cfg_ilim_hi(cfg_ilim_hi),
        .vss_ok(vss_ok), .temp_req(temp_req), .temp_done(temp_done), .lut_capture(lut_capture),
        .dac_load(dac_load), .dac_clear(dac_clear), .clamp_vss(clamp_vss),
        .sw_force_off(sw_force_off), .comm_en(comm_en), .startup_ilim(startup_ilim),
        .ilim_hi(ilim_hi), .pa_on(pa_on), .state_o(state_o)
    );

    // Responders for the external handshakes
    int cfg_cnt = 0;
    int tmp_cnt = 0;
    logic cfg_done_r = 1'b0;
    logic tmp_done_r = 1'b0;
    assign cfg_load_done = cfg_done_r;
    assign temp_done     = tmp_done_r;

    always @(posedge clk) begin
        if (cfg_load_req && !cfg_done_r) begin
            if (cfg_cnt == CFG_LAT) begin cfg_done_r <= 1'b1; cfg_cnt <= 0; end
            else cfg_cnt <= cfg_cnt + 1;
        end else begin
            cfg_done_r <= 1'b0; cfg_cnt <= 0;
        end
        if (temp_req && !tmp_done_r) begin
            if (tmp_cnt == TEMP_LAT) begin tmp_done_r <= 1'b1; tmp_cnt <= 0; end
            else tmp_cnt <= tmp_cnt + 1;
        end else begin
            tmp_done_r <= 1'b0; tmp_cnt <= 0;
        end
    end

    // Behavioural reference: phase number and remaining settle cycles
    int m_ph = 0;
    int m_left = 0;

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_ph = 0; m_left = 0;
        end else if (!ext_rst_n || sw_rst || gc_rst) begin
            m_ph = 0;
        end else begin
            case (m_ph)
                0: m_ph = 1;
                1: if (cfg_load_done) begin
                       if (!cfg_auto) begin m_ph = 6; m_left = TPM * (2 ** cfg_tmr_sel); end
                       else m_ph = cfg_wide_vss ? 2 : 3;
                   end
                2: if (vss_ok) m_ph = 3;
                3: if (temp_done) m_ph = 4;
                4: if (temp_done) m_ph = 5;
                5: begin m_ph = 6; m_left = TPM * (2 ** cfg_tmr_sel); end
                6: begin m_left = m_left - 1; if (m_left == 0) m_ph = 7; end
                default: m_ph = 7;
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (temp_done && temp_req) temp_pulses++;
        if (lut_capture) lut_pulses++;
        if (dac_load) load_pulses++;
        chk(state_o == 3'(m_ph), "R11 state_o", state_o, m_ph);
        chk(clamp_vss == (m_ph <= 1), "R2/R4 clamp_vss", clamp_vss, m_ph <= 1);
        chk(comm_en == (m_ph >= 2), "R3/R4 comm_en", comm_en, m_ph >= 2);
        chk(dac_clear == ((m_ph == 0) ? 4'hF : 4'h0), "R2 dac_clear", dac_clear, (m_ph == 0) ? 15 : 0);
        chk(cfg_load_req == (m_ph == 1), "R3 cfg_load_req", cfg_load_req, m_ph == 1);
        chk(temp_req == (m_ph == 3 || m_ph == 4), "R6 temp_req", temp_req, m_ph == 3 || m_ph == 4);
        chk(lut_capture == (m_ph == 4 && temp_done), "R6 lut_capture", lut_capture, m_ph == 4 && temp_done);
        chk(dac_load == (m_ph == 5), "R6 dac_load", dac_load, m_ph == 5);
        chk(startup_ilim == (m_ph == 6), "R7 startup_ilim", startup_ilim, m_ph == 6);
        chk(sw_force_off == (m_ph != 7), "R4 sw_force_off", sw_force_off, m_ph != 7);
        chk(pa_on == (m_ph == 7), "R8 pa_on", pa_on, m_ph == 7);
        chk(ilim_hi == (m_ph == 7 && cfg_ilim_hi), "R8 ilim_hi", ilim_hi, m_ph == 7 && cfg_ilim_hi);
    end

    task automatic drive_step();
        @(posedge clk); #2;
    endtask

    task automatic wait_phase(input int ph, input int limit);
        for (int i = 0; i < limit; i++) begin
            if (state_o == 3'(ph)) return;
            drive_step();
        end
    endtask

    task automatic measure_settle(input int sel);
        int len;
        len = 0;
        wait_phase(6, 400);
        while (state_o == 3'd6 && len < 200) begin
            len++;
            drive_step();
        end
        chk(len == TPM * (2 ** sel), "R7 settle length", len, TPM * (2 ** sel));
    endtask

    task automatic pulse_soft(input int which);
        drive_step();
        case (which)
            0: ext_rst_n = 1'b0;
            1: sw_rst = 1'b1;
            default: gc_rst = 1'b1;
        endcase
        drive_step();
        ext_rst_n = 1'b1; sw_rst = 1'b0; gc_rst = 1'b0;
        #6;
        chk(state_o == 3'd0, "R1 soft reset to phase 0", state_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #5;
        chk(state_o == 3'd0, "R1 power-on phase", state_o, 0);
        chk(dac_clear == 4'hF && clamp_vss && !pa_on, "R2 reset outputs", dac_clear, 15);
        drive_step();
        por_n = 1'b1;

        // Non-autonomous runs over every settle select (R9, R7)
        for (int s = 0; s < 4; s++) begin
            cfg_auto = 1'b0; cfg_tmr_sel = 2'(s); cfg_ilim_hi = s[0];
            temp_pulses = 0; load_pulses = 0;
            measure_settle(s);
            chk(temp_pulses == 0 && load_pulses == 0, "R9 no conversions", temp_pulses + load_pulses, 0);
            drive_step();
            chk(ilim_hi == s[0], "R8 current mode", ilim_hi, s[0]);
            repeat (40) begin
                cfg_load_req_toggle();
                drive_step();
            end
            chk(state_o == 3'd7 && pa_on, "R10 done hold", state_o, 7);
            pulse_soft(s % 3);
        end

        // Autonomous with supply wait (R5, R6)
        cfg_auto = 1'b1; cfg_wide_vss = 1'b1; vss_ok = 1'b0; cfg_tmr_sel = 2'd1;
        lut_pulses = 0; temp_pulses = 0; load_pulses = 0;
        wait_phase(2, 100);
        repeat (30) drive_step();
        chk(state_o == 3'd2, "R5 supply wait holds", state_o, 2);
        vss_ok = 1'b1;
        measure_settle(1);
        chk(temp_pulses == 2, "R6 two conversions", temp_pulses, 2);
        chk(lut_pulses == 1, "R6 single table capture", lut_pulses, 1);
        chk(load_pulses == 1, "R6 single dac load", load_pulses, 1);
        pulse_soft(2);

        // Autonomous without supply wait (R5)
        cfg_wide_vss = 1'b0; vss_ok = 1'b0; cfg_tmr_sel = 2'd3;
        wait_phase(1, 20);
        wait_phase(3, 40);
        chk(state_o == 3'd3, "R5 supply wait skipped", state_o, 3);
        measure_settle(3);

        // Resets in the middle of each phase (R1)
        cfg_wide_vss = 1'b1; cfg_tmr_sel = 2'd2;
        for (int p = 1; p <= 6; p++) begin
            pulse_soft(0);
            vss_ok = (p == 2) ? 1'b0 : 1'b1;
            wait_phase(p, 200);
            chk(state_o == 3'(p), "R1 reached phase", state_o, p);
            pulse_soft(p % 3);
        end

        // Power-on reset mid-settle (R1)
        vss_ok = 1'b1;
        wait_phase(6, 200);
        drive_step();
        por_n = 1'b0;
        #1;
        chk(state_o == 3'd0 && clamp_vss, "R1 power-on mid-settle", state_o, 0);
        drive_step();
        por_n = 1'b1;
        measure_settle(2);
        repeat (5) drive_step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Stimulus in the done state that must have no effect (R10)
    task automatic cfg_load_req_toggle();
        vss_ok = ~vss_ok;
        cfg_auto = ~cfg_auto;
    endtask

endmodule